// File: doc/BRIEF.md
# Transmit FIFO Packet Reader

This block is the protocol-side consumer of a tagged transmit FIFO. Each FIFO entry is a payload word with a small tag on top. A controller fills the FIFO with a command word, then the packet's data words, then an end-of-packet marker, and strobes `run_pkt`. The reader checks that the head entry is a command and decodes it into a transaction descriptor. It then streams the packet's data to a byte-wide PHY-side interface and reports one completion code when the packet is over.

The reader holds each data word back by one entry, because only the entry after it tells whether the word is the last one. When the last word is known, the byte count carried by the end-of-packet entry sets how many of its bytes go out.

If the FIFO runs dry before the end-of-packet entry arrives, the reader ends the packet with a one-cycle bad-CRC pulse. It then purges: every entry at the head that is not a command is dropped, and the purge stops as soon as the FIFO is empty or a command reaches the head. That command stays in the FIFO for the next strobe. The reader never treats a data word or a marker as a command.

The byte interface uses valid/ready. `byte_valid` may only fall after a handshake. While `byte_valid` is high and `byte_ready` is low, `byte_data` and `byte_last` hold their values. The sink may hold `byte_ready` low for any length of time.

Top module: `txq_pkt_reader`

## Requirements
- R1: After a synchronous reset, `desc_valid`, `byte_valid`, `done_valid`, `tx_bad_crc` and `fifo_pop` are all low.
- R2: When `run_pkt` is seen in idle with a tag 0 (command) entry at the head, that entry is popped, and `desc_valid` pulses one cycle later. The command word is decoded as follows: PID in bits 3:0, toggle in bits 5:4, type in bits 7:6, speed in bits 9:8, device address in bits 22:16, endpoint in bits 29:23. The tag sits in bits 35:32 of the FIFO entry.
- R3: When `run_pkt` is seen in idle with the FIFO empty, or with a head whose tag is not 0, nothing is popped, no descriptor is issued, and the completion code is 2 (protocol error).
- R4: Entries with tag 1 are data words. Each data word is sent least-significant byte first. Every word except the last sends all 4 bytes. Data and last-flag hold steady while `byte_valid` is high and `byte_ready` is low.
- R5: An entry with tag 2 ends the packet. Its bits 2:0 give the number of valid bytes (1 to 4) in the last data word; a value of 0 or above 4 means 4. `byte_last` is high on the final byte.
- R6: A tag 2 entry that directly follows the command ends a zero-length packet. No bytes are sent, and the completion code is 0 (success).
- R7: If the FIFO is empty while the reader needs the next entry of a packet, `tx_bad_crc` pulses for one cycle. No further bytes of that packet are sent, and a data word that was held back is dropped.
- R8: After the bad-CRC pulse, the reader pops and discards head entries whose tag is not 0, including tag 2 entries. It stops when the FIFO is empty or the head has tag 0, and leaves that command in the FIFO. The completion code is then 1 (underrun).
- R9: Each accepted strobe gives exactly one `done_valid` pulse. A `run_pkt` that arrives while a packet is active is ignored.
- R10: If, during a packet, the head entry carries tag 0 or an undefined tag where a data word or end marker was expected, that entry is not popped. The completion code is 2, and no byte of the held-back word is sent.
- R11: `fifo_pop` is never high while `fifo_empty` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_pkt | input | 1 | Strobe: start the packet whose command is at the FIFO head |
| fifo_rd_data | input | 36 | FIFO head entry: tag in 35:32, payload in 31:0 |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_pop | output | 1 | Removes the head entry at this clock edge |
| desc_valid | output | 1 | One-cycle pulse: descriptor fields are new |
| desc_pid | output | 4 | Decoded PID |
| desc_toggle | output | 2 | Decoded data toggle |
| desc_type | output | 2 | Decoded endpoint type |
| desc_speed | output | 2 | Decoded endpoint speed |
| desc_addr | output | 7 | Decoded device address |
| desc_ep | output | 7 | Decoded endpoint number |
| byte_valid | output | 1 | Byte stream valid |
| byte_ready | input | 1 | Byte stream ready |
| byte_data | output | 8 | Byte stream data |
| byte_last | output | 1 | Final byte of the packet |
| tx_bad_crc | output | 1 | One-cycle pulse: the packet is ended with a forced bad CRC |
| done_valid | output | 1 | One-cycle completion pulse |
| done_status | output | 2 | Completion code: 0 success, 1 underrun, 2 protocol error |

## Verification
Most faults in the sequencing state are visible at the ports within one packet. If the held-back word or its flag is wrong, a byte is lost, duplicated or flagged last at the wrong point. If the purge stop condition is wrong, the pending command is either swallowed or left behind along with junk. Both show up a few cycles later, as a descriptor that never appears or as a protocol-error completion on the next strobe. If the byte counter is wrong, the packet's byte count is off on its last word. A state that never returns to idle shows up as a missing completion pulse, which the bench flags after a bounded wait.

// File: rtl/txq_pkg.sv
package txq_pkg;

  // Tag codes carried in the top bits of each FIFO entry
  localparam int TAG_SOP  = 0;
  localparam int TAG_DATA = 1;
  localparam int TAG_EOP  = 2;

  // Command-word field positions
  localparam int PID_LSB = 0;
  localparam int TGL_LSB = 4;
  localparam int TYP_LSB = 6;
  localparam int SPD_LSB = 8;
  localparam int ADR_LSB = 16;
  localparam int EPN_LSB = 23;
  localparam int CMD_MIN_W = 30;

  typedef enum logic [1:0] {
    ST_OK       = 2'd0,
    ST_UNDERRUN = 2'd1,
    ST_PROTO    = 2'd2
  } done_code_e;

  typedef enum logic [1:0] {
    RD_IDLE,
    RD_STREAM,
    RD_DRAIN,
    RD_PURGE
  } rd_state_e;

  typedef struct packed {
    logic [6:0] ep;
    logic [6:0] addr;
    logic [1:0] speed;
    logic [1:0] xtype;
    logic [1:0] toggle;
    logic [3:0] pid;
  } cmd_desc_t;

endpackage

// File: rtl/txq_cmd_decode.sv
module txq_cmd_decode
  import txq_pkg::*;
#(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] cmd_word,
  output cmd_desc_t         desc
);

  // A word narrower than the field layout cannot carry a command
  generate
    if (WORD_W < CMD_MIN_W) begin : g_bad_width
      initial $error("txq_cmd_decode: WORD_W too small for command layout");
    end
  endgenerate

  always_comb begin
    desc.pid    = cmd_word[PID_LSB +: 4];
    desc.toggle = cmd_word[TGL_LSB +: 2];
    desc.xtype  = cmd_word[TYP_LSB +: 2];
    desc.speed  = cmd_word[SPD_LSB +: 2];
    desc.addr   = cmd_word[ADR_LSB +: 7];
    desc.ep     = cmd_word[EPN_LSB +: 7];
  end

endmodule

// File: rtl/txq_byte_emit.sv
module txq_byte_emit #(
  parameter int WORD_W = 32,
  localparam int BYTES = WORD_W / 8,
  localparam int CNT_W = $clog2(BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [WORD_W-1:0] load_word,
  input  logic [CNT_W-1:0]  load_cnt,
  input  logic              load_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              busy
);

  logic [WORD_W-1:0] word_q;
  logic [CNT_W-1:0]  left_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      left_q <= '0;
      last_q <= 1'b0;
    end else if (load) begin
      word_q <= load_word;
      left_q <= load_cnt;
      last_q <= load_last;
    end else if (out_valid && out_ready) begin
      word_q <= word_q >> 8;
      left_q <= left_q - 1'b1;
    end
  end

  assign out_valid = (left_q != '0);
  assign out_data  = word_q[7:0];
  assign out_last  = last_q && (left_q == CNT_W'(1));
  assign busy      = out_valid;

endmodule

// File: rtl/txq_pkt_reader.sv
module txq_pkt_reader
  import txq_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int TAG_W  = 4,
  localparam int ENTRY_W = TAG_W + WORD_W,
  localparam int BYTES   = WORD_W / 8,
  localparam int CNT_W   = $clog2(BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               run_pkt,
  input  logic [ENTRY_W-1:0] fifo_rd_data,
  input  logic               fifo_empty,
  output logic               fifo_pop,
  output logic               desc_valid,
  output logic [3:0]         desc_pid,
  output logic [1:0]         desc_toggle,
  output logic [1:0]         desc_type,
  output logic [1:0]         desc_speed,
  output logic [6:0]         desc_addr,
  output logic [6:0]         desc_ep,
  output logic               byte_valid,
  input  logic               byte_ready,
  output logic [7:0]         byte_data,
  output logic               byte_last,
  output logic               tx_bad_crc,
  output logic               done_valid,
  output logic [1:0]         done_status
);

  // Head entry split
  logic [TAG_W-1:0]  head_tag;
  logic [WORD_W-1:0] head_pay;
  logic              is_sop, is_data, is_eop;
  logic [CNT_W-1:0]  eop_raw, eop_cnt;

  assign head_tag = fifo_rd_data[ENTRY_W-1:WORD_W];
  assign head_pay = fifo_rd_data[WORD_W-1:0];
  assign is_sop   = (head_tag == TAG_W'(TAG_SOP));
  assign is_data  = (head_tag == TAG_W'(TAG_DATA));
  assign is_eop   = (head_tag == TAG_W'(TAG_EOP));
  assign eop_raw  = head_pay[CNT_W-1:0];
  assign eop_cnt  = ((eop_raw == '0) || (eop_raw > CNT_W'(BYTES))) ? CNT_W'(BYTES) : eop_raw;

  // State
  rd_state_e         state_q, state_d;
  logic              hold_v_q;
  logic [WORD_W-1:0] hold_q;
  cmd_desc_t         desc_q, desc_dec;
  logic              desc_valid_q, done_valid_q, bad_crc_q;
  done_code_e        done_code_q;
  logic              in_purge;

  // Next-state controls
  logic              pop_c, desc_fire, done_fire, crc_fire;
  done_code_e        done_code;
  logic              hold_load, hold_clr;
  logic              emit_load, emit_last, emit_busy;
  logic [CNT_W-1:0]  emit_cnt;

  txq_cmd_decode #(.WORD_W(WORD_W)) u_dec (
    .cmd_word (head_pay),
    .desc     (desc_dec)
  );

  txq_byte_emit #(.WORD_W(WORD_W)) u_emit (
    .clk       (clk),
    .rst       (rst),
    .load      (emit_load),
    .load_word (hold_q),
    .load_cnt  (emit_cnt),
    .load_last (emit_last),
    .out_valid (byte_valid),
    .out_ready (byte_ready),
    .out_data  (byte_data),
    .out_last  (byte_last),
    .busy      (emit_busy)
  );

  always_comb begin
    state_d   = state_q;
    pop_c     = 1'b0;
    desc_fire = 1'b0;
    done_fire = 1'b0;
    done_code = ST_OK;
    crc_fire  = 1'b0;
    hold_load = 1'b0;
    hold_clr  = 1'b0;
    emit_load = 1'b0;
    emit_cnt  = CNT_W'(BYTES);
    emit_last = 1'b0;
    unique case (state_q)
      RD_IDLE: begin
        if (run_pkt) begin
          if (!fifo_empty && is_sop) begin
            pop_c     = 1'b1;
            desc_fire = 1'b1;
            state_d   = RD_STREAM;
          end else begin
            done_fire = 1'b1;
            done_code = ST_PROTO;
          end
        end
      end
      RD_STREAM: begin
        if (!emit_busy) begin
          if (fifo_empty) begin
            // Underrun: force bad CRC, drop held word, then purge
            crc_fire = 1'b1;
            hold_clr = 1'b1;
            state_d  = RD_PURGE;
          end else if (is_data) begin
            pop_c     = 1'b1;
            hold_load = 1'b1;
            emit_load = hold_v_q;
          end else if (is_eop) begin
            pop_c = 1'b1;
            if (hold_v_q) begin
              emit_load = 1'b1;
              emit_cnt  = eop_cnt;
              emit_last = 1'b1;
              hold_clr  = 1'b1;
              state_d   = RD_DRAIN;
            end else begin
              done_fire = 1'b1;
              done_code = ST_OK;
              state_d   = RD_IDLE;
            end
          end else begin
            done_fire = 1'b1;
            done_code = ST_PROTO;
            hold_clr  = 1'b1;
            state_d   = RD_IDLE;
          end
        end
      end
      RD_DRAIN: begin
        if (!emit_busy) begin
          done_fire = 1'b1;
          done_code = ST_OK;
          state_d   = RD_IDLE;
        end
      end
      RD_PURGE: begin
        if (fifo_empty || is_sop) begin
          done_fire = 1'b1;
          done_code = ST_UNDERRUN;
          state_d   = RD_IDLE;
        end else begin
          pop_c = 1'b1;
        end
      end
      default: state_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= RD_IDLE;
      hold_v_q     <= 1'b0;
      hold_q       <= '0;
      desc_q       <= '0;
      desc_valid_q <= 1'b0;
      done_valid_q <= 1'b0;
      done_code_q  <= ST_OK;
      bad_crc_q    <= 1'b0;
    end else begin
      state_q      <= state_d;
      desc_valid_q <= desc_fire;
      done_valid_q <= done_fire;
      bad_crc_q    <= crc_fire;
      if (desc_fire) desc_q <= desc_dec;
      if (done_fire) done_code_q <= done_code;
      if (hold_load) begin
        hold_q   <= head_pay;
        hold_v_q <= 1'b1;
      end else if (hold_clr) begin
        hold_v_q <= 1'b0;
      end
    end
  end

  assign in_purge    = (state_q == RD_PURGE);
  assign fifo_pop    = pop_c;
  assign desc_valid  = desc_valid_q;
  assign desc_pid    = desc_q.pid;
  assign desc_toggle = desc_q.toggle;
  assign desc_type   = desc_q.xtype;
  assign desc_speed  = desc_q.speed;
  assign desc_addr   = desc_q.addr;
  assign desc_ep     = desc_q.ep;
  assign tx_bad_crc  = bad_crc_q;
  assign done_valid  = done_valid_q;
  assign done_status = done_code_q;

endmodule

// File: rtl/txq_pkt_reader_chk.sv
module txq_pkt_reader_chk #(
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             fifo_empty,
  input logic             fifo_pop,
  input logic [TAG_W-1:0] head_tag,
  input logic             in_purge,
  input logic             desc_valid,
  input logic             byte_valid,
  input logic             byte_ready,
  input logic [7:0]       byte_data,
  input logic             byte_last,
  input logic             tx_bad_crc,
  input logic             done_valid,
  input logic [1:0]       done_status
);

  a_r11_no_pop_when_empty: assert property (@(posedge clk) disable iff (rst)
    fifo_pop |-> !fifo_empty);

  a_r4_byte_held_under_stall: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data) && $stable(byte_last)));

  a_r2_desc_follows_pop: assert property (@(posedge clk) disable iff (rst)
    desc_valid |-> $past(fifo_pop));

  a_r7_bad_crc_ends_bytes: assert property (@(posedge clk) disable iff (rst)
    tx_bad_crc |-> !byte_valid);

  a_r8_purge_keeps_command: assert property (@(posedge clk) disable iff (rst)
    (in_purge && !fifo_empty && head_tag == '0) |-> !fifo_pop);

  a_r9_done_is_single_pulse: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  a_r9_done_code_legal: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> (done_status != 2'd3));

endmodule

bind txq_pkt_reader txq_pkt_reader_chk #(.TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .fifo_empty  (fifo_empty),
  .fifo_pop    (fifo_pop),
  .head_tag    (head_tag),
  .in_purge    (in_purge),
  .desc_valid  (desc_valid),
  .byte_valid  (byte_valid),
  .byte_ready  (byte_ready),
  .byte_data   (byte_data),
  .byte_last   (byte_last),
  .tx_bad_crc  (tx_bad_crc),
  .done_valid  (done_valid),
  .done_status (done_status)
);

// File: tb/txq_pkt_reader_tb_top.sv
module txq_pkt_reader_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_pkt = 1'b0;
  logic [35:0] head = '0;
  logic        fifo_empty = 1'b1;
  logic        fifo_pop;
  logic        desc_valid;
  logic [3:0]  desc_pid;
  logic [1:0]  desc_toggle, desc_type, desc_speed;
  logic [6:0]  desc_addr, desc_ep;
  logic        byte_valid, byte_ready = 1'b0, byte_last;
  logic [7:0]  byte_data;
  logic        tx_bad_crc, done_valid;
  logic [1:0]  done_status;

  always #5 clk = ~clk;

  txq_pkt_reader dut_i (
    .clk(clk), .rst(rst), .run_pkt(run_pkt), .fifo_rd_data(head),
    .fifo_empty(fifo_empty), .fifo_pop(fifo_pop), .desc_valid(desc_valid),
    .desc_pid(desc_pid), .desc_toggle(desc_toggle), .desc_type(desc_type),
    .desc_speed(desc_speed), .desc_addr(desc_addr), .desc_ep(desc_ep),
    .byte_valid(byte_valid), .byte_ready(byte_ready), .byte_data(byte_data),
    .byte_last(byte_last), .tx_bad_crc(tx_bad_crc), .done_valid(done_valid),
    .done_status(done_status)
  );

  logic [35:0] fq[$];
  logic [8:0]  exp_bytes[$];
  logic [31:0] exp_desc[$];
  logic [1:0]  exp_done[$];
  int exp_crc = 0;
  int n_vec = 0, n_bad = 0, cyc = 0;
  bit stall = 1'b0, finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  function automatic logic [31:0] wdata(input int seed, input int i);
    logic [7:0] b;
    b = 8'(seed + 4 * i);
    return {b + 8'd3, b + 8'd2, b + 8'd1, b};
  endfunction

  function automatic logic [31:0] mkcmd(input logic [3:0] pid, input logic [1:0] tgl,
      input logic [1:0] typ, input logic [1:0] spd, input logic [6:0] adr, input logic [6:0] ep);
    return {2'b00, ep, adr, 6'b0, spd, typ, tgl, pid};
  endfunction

  // FIFO model: pop after the edge at which the design asked for it
  always @(posedge clk) begin
    bit p;
    p = fifo_pop;
    #1;
    if (p) begin
      if (fq.size() == 0) chk(1'b0, "R11", "pop while empty", 1, 0);
      else void'(fq.pop_front());
      fifo_empty = (fq.size() == 0);
      head = fifo_empty ? 36'h0 : fq[0];
    end
  end

  task automatic push(input logic [35:0] e);
    fq.push_back(e);
    head = fq[0];
    fifo_empty = 1'b0;
  endtask

  task automatic push_body(input int n, input int cnt, input int seed);
    for (int i = 0; i < n; i++) push({4'h1, wdata(seed, i)});
    push({4'h2, 32'(cnt)});
  endtask

  task automatic expect_pkt(input logic [31:0] cmd, input int n, input int cnt,
                            input int seed, input logic [1:0] st);
    int eff;
    eff = (cnt == 0 || cnt > 4) ? 4 : cnt;
    exp_desc.push_back(cmd);
    for (int i = 0; i < n; i++) begin
      int nb;
      logic [31:0] w;
      nb = (i == n - 1) ? eff : 4;
      w = wdata(seed, i);
      for (int b = 0; b < nb; b++)
        exp_bytes.push_back({(i == n - 1) && (b == nb - 1), w[8*b +: 8]});
    end
    exp_done.push_back(st);
  endtask

  task automatic pulse_run();
    @(negedge clk) run_pkt = 1'b1;
    @(negedge clk) run_pkt = 1'b0;
  endtask

  task automatic wait_idle(input string req);
    int t;
    t = 0;
    while ((exp_done.size() != 0 || exp_bytes.size() != 0) && t < 3000) begin
      @(negedge clk);
      t++;
    end
    chk(t < 3000, req, "completion timeout", t, 0);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: drive ready, compare outputs against the scoreboard
  always @(negedge clk) begin
    cyc++;
    byte_ready = stall ? 1'b0 : ((cyc % 4) != 2);
    if (!rst) begin
      if (byte_valid && byte_ready) begin
        if (exp_bytes.size() == 0) chk(1'b0, "R4", "unexpected byte", byte_data, 0);
        else begin
          logic [8:0] e;
          e = exp_bytes.pop_front();
          chk({byte_last, byte_data} == e, "R4 R5", "byte/last", {byte_last, byte_data}, e);
        end
      end
      if (desc_valid) begin
        if (exp_desc.size() == 0) chk(1'b0, "R2", "unexpected descriptor", 1, 0);
        else begin
          logic [31:0] c;
          c = exp_desc.pop_front();
          chk({desc_ep, desc_addr, desc_speed, desc_type, desc_toggle, desc_pid} ==
              {c[29:23], c[22:16], c[9:8], c[7:6], c[5:4], c[3:0]}, "R2", "descriptor",
              {desc_ep, desc_addr, desc_speed, desc_type, desc_toggle, desc_pid},
              {c[29:23], c[22:16], c[9:8], c[7:6], c[5:4], c[3:0]});
        end
      end
      if (done_valid) begin
        if (exp_done.size() == 0) chk(1'b0, "R9", "unexpected completion", done_status, 0);
        else begin
          logic [1:0] s;
          s = exp_done.pop_front();
          chk(done_status == s, "R9", "completion code", done_status, s);
        end
      end
      if (tx_bad_crc) begin
        chk(exp_crc > 0, "R7", "unexpected bad-CRC pulse", 1, exp_crc);
        exp_crc--;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WATCHDOG", "run did not finish", cyc, 0);
    report();
  end

  initial begin
    logic [31:0] c1, c2;
    repeat (5) @(negedge clk);
    chk({desc_valid, byte_valid, done_valid, tx_bad_crc, fifo_pop} == 5'b0, "R1",
        "outputs in reset", {desc_valid, byte_valid, done_valid, tx_bad_crc, fifo_pop}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk({desc_valid, byte_valid, done_valid, tx_bad_crc, fifo_pop} == 5'b0, "R1",
        "outputs after reset", {desc_valid, byte_valid, done_valid, tx_bad_crc, fifo_pop}, 0);

    // R2 R4 R5: three words, two bytes in the last
    c1 = mkcmd(4'h1, 2'd1, 2'd2, 2'd2, 7'h55, 7'h3a);
    push({4'h0, c1}); push_body(3, 2, 16); expect_pkt(c1, 3, 2, 16, 2'd0);
    pulse_run(); wait_idle("R2 R4 R5");

    // R5: count 0 and count above 4 both mean a full last word; count 1
    c1 = mkcmd(4'h9, 2'd0, 2'd1, 2'd0, 7'h01, 7'h7f);
    push({4'h0, c1}); push_body(2, 0, 40); expect_pkt(c1, 2, 0, 40, 2'd0);
    pulse_run(); wait_idle("R5 count 0");
    c1 = mkcmd(4'hd, 2'd3, 2'd3, 2'd1, 7'h7f, 7'h00);
    push({4'h0, c1}); push_body(1, 7, 60); expect_pkt(c1, 1, 7, 60, 2'd0);
    pulse_run(); wait_idle("R5 count 7");
    c1 = mkcmd(4'h3, 2'd2, 2'd0, 2'd3, 7'h22, 7'h11);
    push({4'h0, c1}); push_body(1, 1, 80); expect_pkt(c1, 1, 1, 80, 2'd0);
    pulse_run(); wait_idle("R5 count 1");

    // R6: zero-length packet
    c1 = mkcmd(4'h5, 2'd0, 2'd0, 2'd0, 7'h10, 7'h02);
    push({4'h0, c1}); push_body(0, 0, 0); expect_pkt(c1, 0, 0, 0, 2'd0);
    pulse_run(); wait_idle("R6");
    chk(fq.size() == 0, "R6", "FIFO left after zero-length", fq.size(), 0);

    // R3: strobe with empty FIFO, then with a data word at the head
    exp_done.push_back(2'd2);
    pulse_run(); wait_idle("R3 empty");
    push({4'h1, 32'hdeadbeef});
    exp_done.push_back(2'd2);
    pulse_run(); wait_idle("R3 data head");
    chk(fq.size() == 1, "R3", "non-command head popped", fq.size(), 1);
    fq.delete(); fifo_empty = 1'b1; head = '0;

    // R7 R8: underrun after one full word, purge of leftovers up to next command
    c1 = mkcmd(4'h1, 2'd0, 2'd2, 2'd2, 7'h33, 7'h04);
    c2 = mkcmd(4'he, 2'd1, 2'd2, 2'd2, 7'h44, 7'h05);
    push({4'h0, c1}); push({4'h1, wdata(100, 0)}); push({4'h1, wdata(100, 1)});
    exp_desc.push_back(c1);
    for (int b = 0; b < 4; b++) exp_bytes.push_back({1'b0, wdata(100, 0) >> (8 * b)}[8:0] & 9'h0ff);
    exp_done.push_back(2'd1);
    exp_crc = 1;
    pulse_run();
    begin
      int t;
      t = 0;
      while (!tx_bad_crc && t < 2000) begin @(negedge clk); t++; end
      chk(t < 2000, "R7", "bad-CRC pulse missing", t, 0);
    end
    push({4'h1, 32'h0badf00d}); push({4'h2, 32'h3});
    push({4'h0, c2}); push_body(2, 3, 120);
    wait_idle("R7 R8");
    chk(fq.size() == 4, "R8", "entries left after purge", fq.size(), 4);
    chk(fq.size() != 0 && fq[0] == {4'h0, c2}, "R8", "command kept at head",
        fq.size() != 0 ? fq[0] : 36'h0, {4'h0, c2});
    expect_pkt(c2, 2, 3, 120, 2'd0);
    pulse_run(); wait_idle("R8 next command");
    chk(exp_crc == 0, "R7", "bad-CRC pulse count", exp_crc, 0);

    // R7: underrun right after the command, nothing to purge
    c1 = mkcmd(4'h2, 2'd0, 2'd0, 2'd1, 7'h09, 7'h09);
    push({4'h0, c1});
    exp_desc.push_back(c1); exp_done.push_back(2'd1); exp_crc = 1;
    pulse_run(); wait_idle("R7 no data");
    chk(exp_crc == 0, "R7", "bad-CRC pulse after bare command", exp_crc, 0);

    // R10: command where data was expected; held word is dropped, command kept
    c1 = mkcmd(4'h6, 2'd1, 2'd1, 2'd1, 7'h66, 7'h06);
    c2 = mkcmd(4'h7, 2'd2, 2'd1, 2'd1, 7'h67, 7'h07);
    push({4'h0, c1}); push({4'h1, wdata(140, 0)}); push({4'h0, c2});
    exp_desc.push_back(c1); exp_done.push_back(2'd2);
    pulse_run(); wait_idle("R10");
    chk(fq.size() == 1 && fq[0] == {4'h0, c2}, "R10", "unexpected command not popped",
        fq.size(), 1);
    push_body(1, 2, 160); expect_pkt(c2, 1, 2, 160, 2'd0);
    pulse_run(); wait_idle("R10 follow-up");

    // R9: second strobe while the packet is stalled is ignored
    c1 = mkcmd(4'h8, 2'd0, 2'd3, 2'd2, 7'h70, 7'h08);
    stall = 1'b1;
    push({4'h0, c1}); push_body(2, 4, 180); expect_pkt(c1, 2, 4, 180, 2'd0);
    pulse_run();
    repeat (4) @(negedge clk);
    pulse_run();
    repeat (4) @(negedge clk);
    stall = 1'b0;
    wait_idle("R9");
    repeat (10) @(negedge clk);
    chk(exp_done.size() == 0 && exp_desc.size() == 0, "R9", "leftover expectations",
        exp_done.size() + exp_desc.size(), 0);
    chk(fq.size() == 0, "R9", "FIFO after ignored strobe", fq.size(), 0);

    report();
  end

endmodule